// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block converts between an NRZ serial bit stream and the pulse signalling used by an infrared serial link. On the transmit side, every NRZ zero bit becomes one short high pulse on the infrared output. NRZ one bits and the idle line produce nothing, so the output stays low. On the receive side, low pulses on the infrared receive line are turned back into NRZ zero bits. The receive line is active low, which is how infrared receiver modules report light.

Bit timing comes from a 16x bit-rate tick supplied by the surrounding serial controller, and each bit spans sixteen ticks. Two pulse modes are available:
- In normal mode, the transmit pulse lasts three of the sixteen ticks of a bit.
- In low-power mode, the pulse width is set by a slower reference period of `lp_div` system clock cycles instead. The same reference period also sets the glitch filter on the receive side.

The prescaler is chosen so that this reference period is roughly 1.4 to 2.1 MHz. Serial framing, baud-rate generation and the analog transceiver are all outside this block.

Top module: `irda_sir_codec`

## Requirements
- R1: After reset `ir_tx` is 0 and `rx_nrz` is 1. `ir_tx` is high only while a pulse for a zero bit is being sent, and a one bit or an idle line produces no pulse.
- R2: `tx_nrz` is sampled on a tick at every bit boundary (every 16 ticks while busy, any tick while idle). In normal mode each sampled zero gives exactly one `ir_tx` pulse, starting with that tick and lasting 3 tick periods.
- R3: In low-power mode each sampled zero gives one `ir_tx` pulse of exactly 3·D system clock cycles, where D is the effective prescaler value.
- R4: An `lp_div` value of 0 behaves as D = 1. Any other value gives D = `lp_div`.
- R5: In normal mode `lp_div` has no effect: the transmit width and the receive acceptance are the same for any prescaler value.
- R6: `rx_ir` passes through a 2-flop synchronizer. In normal mode any low lasting at least one system clock cycle is accepted as a zero bit.
- R7: In low-power mode a low on `rx_ir` lasting 2·D cycles or fewer is rejected as a glitch, and `rx_nrz` stays 1.
- R8: In low-power mode a low on `rx_ir` lasting at least 2·D+1 cycles is accepted, and `rx_nrz` goes to 0.
- R9: An accepted pulse keeps `rx_nrz` at 0 until 16 ticks have elapsed since the synchronized start of the pulse. `rx_nrz` then returns to 1 on a tick.
- R10: A byte sent through `ir_tx` and looped back inverted into `rx_ir` is rebuilt bit for bit on `rx_nrz` in both modes, including runs of consecutive zero bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| lp_mode | input | 1 | 1 selects low-power pulse mode, 0 selects normal mode |
| lp_div | input | DIV_W | Prescaler: system clock cycles per low-power reference period |
| tx_nrz | input | 1 | NRZ transmit bit stream |
| rx_ir | input | 1 | Raw infrared receive line, active low |
| ir_tx | output | 1 | Infrared transmit pulse, active high |
| rx_nrz | output | 1 | Decoded NRZ receive bit stream |

## Verification
The assertions check the following on every cycle:
- A transmit pulse only ever starts from a zero on `tx_nrz`.
- Normal-mode pulses end on a tick.
- Every low-power pulse is exactly three reference periods long.
- A low-power decode never begins before the synchronized low has lasted the acceptance length.
- The decoded output returns high only on a tick.

Some behaviour only the bench scenarios can show:
- That lows at or just below the 2·D boundary produce no output at all.
- That a zero prescaler acts as one.
- That the decode window counts exactly sixteen ticks.
- That a looped-back byte comes back with the right bit values in the right places.

// File: rtl/irda_sir_pkg.sv
`timescale 1ns/1ps
package irda_sir_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_PEND = 2'd1,
    RX_ACT  = 2'd2
  } rx_state_e;

  // Effective prescaler: zero is promoted to one.
  function automatic int unsigned eff_div(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // Transmit pulse length in low-power mode, in system clock cycles.
  function automatic int unsigned lp_pulse_cycles(input int unsigned d,
                                                  input int unsigned periods);
    return periods * eff_div(d);
  endfunction

  // Minimum synchronized low length accepted in low-power mode.
  function automatic int unsigned lp_accept_cycles(input int unsigned d,
                                                   input int unsigned periods);
    return periods * eff_div(d) + 1;
  endfunction

endpackage

// File: rtl/sir_tx_enc.sv
`timescale 1ns/1ps
module sir_tx_enc
  import irda_sir_pkg::*;
#(
  parameter int DIV_W            = 8,
  parameter int TICKS_PER_BIT    = 16,
  parameter int PULSE_TICKS      = 3,
  parameter int LP_PULSE_PERIODS = 3,
  parameter int CW               = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             tx_nrz,
  output logic             ir_tx
);
  localparam int TW = $clog2(TICKS_PER_BIT);

  logic          busy_q;
  logic [TW-1:0] tick_q;
  logic [CW-1:0] lp_left_q;
  logic [CW-1:0] lp_len;
  logic          bit_edge;
  logic          start;

  always_comb begin
    lp_len   = CW'(lp_pulse_cycles(32'(lp_div), LP_PULSE_PERIODS));
    bit_edge = tick16 && (!busy_q || (tick_q == TW'(TICKS_PER_BIT - 1)));
    start    = bit_edge && !tx_nrz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      tick_q    <= '0;
      lp_left_q <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        tick_q <= '0;
      end else if (bit_edge) begin
        busy_q <= 1'b0;
        tick_q <= '0;
      end else if (busy_q && tick16) begin
        tick_q <= tick_q + 1'b1;
      end
      if (start)
        lp_left_q <= lp_len;
      else if (lp_left_q != '0)
        lp_left_q <= lp_left_q - 1'b1;
    end
  end

  assign ir_tx = busy_q && (lp_mode ? (lp_left_q != '0)
                                    : (tick_q < TW'(PULSE_TICKS)));

endmodule

// File: rtl/sir_rx_dec.sv
`timescale 1ns/1ps
module sir_rx_dec
  import irda_sir_pkg::*;
#(
  parameter int DIV_W             = 8,
  parameter int TICKS_PER_BIT     = 16,
  parameter int LP_ACCEPT_PERIODS = 2,
  parameter int SYNC_STAGES       = 2,
  parameter int CW                = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             rx_ir,
  output logic             rx_nrz,
  output logic             line_low
);
  localparam int TW = $clog2(TICKS_PER_BIT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   armed_q;
  rx_state_e              state_q;
  logic [TW-1:0]          tick_q;
  logic [CW-1:0]          low_q;
  logic [CW-1:0]          thr_m1;
  logic                   start;
  logic                   win_done;

  always_comb begin
    line_low = !sync_q[SYNC_STAGES-1];
    thr_m1   = CW'(lp_accept_cycles(32'(lp_div), LP_ACCEPT_PERIODS) - 1);
    start    = (state_q == RX_IDLE) && line_low && armed_q;
    win_done = (state_q != RX_IDLE) && tick16 &&
               (tick_q == TW'(TICKS_PER_BIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      armed_q <= 1'b1;
      state_q <= RX_IDLE;
      tick_q  <= '0;
      low_q   <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_ir};
      if (!line_low)
        armed_q <= 1'b1;
      else if (start)
        armed_q <= 1'b0;
      if ((state_q != RX_IDLE) && tick16)
        tick_q <= tick_q + 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          if (start) begin
            state_q <= lp_mode ? RX_PEND : RX_ACT;
            tick_q  <= '0;
            low_q   <= CW'(1);
          end
        end
        RX_PEND: begin
          if (win_done || !line_low)
            state_q <= RX_IDLE;
          else if (low_q == thr_m1)
            state_q <= RX_ACT;
          else
            low_q <= low_q + 1'b1;
        end
        RX_ACT: begin
          if (win_done)
            state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign rx_nrz = (state_q != RX_ACT);

endmodule

// File: rtl/irda_sir_codec.sv
`timescale 1ns/1ps
module irda_sir_codec #(
  parameter int DIV_W             = 8,
  parameter int TICKS_PER_BIT     = 16,
  parameter int PULSE_TICKS       = 3,
  parameter int LP_PULSE_PERIODS  = 3,
  parameter int LP_ACCEPT_PERIODS = 2,
  parameter int SYNC_STAGES       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             tx_nrz,
  input  logic             rx_ir,
  output logic             ir_tx,
  output logic             rx_nrz
);
  localparam int CW = DIV_W + $clog2(LP_PULSE_PERIODS + LP_ACCEPT_PERIODS + 1);

  logic rx_low_s;

  sir_tx_enc #(
    .DIV_W(DIV_W), .TICKS_PER_BIT(TICKS_PER_BIT), .PULSE_TICKS(PULSE_TICKS),
    .LP_PULSE_PERIODS(LP_PULSE_PERIODS), .CW(CW)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .lp_mode(lp_mode),
    .lp_div(lp_div), .tx_nrz(tx_nrz), .ir_tx(ir_tx)
  );

  sir_rx_dec #(
    .DIV_W(DIV_W), .TICKS_PER_BIT(TICKS_PER_BIT),
    .LP_ACCEPT_PERIODS(LP_ACCEPT_PERIODS), .SYNC_STAGES(SYNC_STAGES), .CW(CW)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .lp_mode(lp_mode),
    .lp_div(lp_div), .rx_ir(rx_ir), .rx_nrz(rx_nrz), .line_low(rx_low_s)
  );

endmodule

// File: rtl/irda_sir_codec_chk.sv
`timescale 1ns/1ps
module irda_sir_codec_chk
  import irda_sir_pkg::*;
#(
  parameter int DIV_W             = 8,
  parameter int LP_PULSE_PERIODS  = 3,
  parameter int LP_ACCEPT_PERIODS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick16,
  input logic             lp_mode,
  input logic [DIV_W-1:0] lp_div,
  input logic             tx_nrz,
  input logic             ir_tx,
  input logic             rx_nrz,
  input logic             rx_low_s
);
  logic [15:0] hi_len;
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len  <= '0;
      low_run <= '0;
    end else begin
      hi_len  <= ir_tx ? ((hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1) : '0;
      low_run <= rx_low_s ? ((low_run == 16'hFFFF) ? low_run : low_run + 1'b1) : '0;
    end
  end

  AST_TX_PULSE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> $past(!tx_nrz)); // R1

  AST_NORM_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_mode && $fell(ir_tx)) |-> $past(tick16)); // R2

  AST_LP_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && $fell(ir_tx)) |->
      (32'(hi_len) == lp_pulse_cycles(32'(lp_div), LP_PULSE_PERIODS))); // R3

  AST_LP_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && $fell(rx_nrz)) |->
      (32'(low_run) >= lp_accept_cycles(32'(lp_div), LP_ACCEPT_PERIODS))); // R7

  AST_RX_WINDOW_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_nrz) |-> $past(tick16)); // R9

endmodule

bind irda_sir_codec irda_sir_codec_chk #(
  .DIV_W(DIV_W), .LP_PULSE_PERIODS(LP_PULSE_PERIODS),
  .LP_ACCEPT_PERIODS(LP_ACCEPT_PERIODS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .lp_mode(lp_mode),
  .lp_div(lp_div), .tx_nrz(tx_nrz), .ir_tx(ir_tx), .rx_nrz(rx_nrz),
  .rx_low_s(rx_low_s)
);

// File: tb/irda_sir_codec_bench.sv
`timescale 1ns/1ps
module irda_sir_codec_bench;

  localparam int TICK_CYC = 8;
  localparam int NVEC     = 8;
  // {lp_mode, lp_div, data byte}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'd0,   8'hA5},
    {1'b0, 8'd200, 8'h00},
    {1'b0, 8'd7,   8'hFF},
    {1'b1, 8'd5,   8'h35},
    {1'b1, 8'd0,   8'h0F},
    {1'b1, 8'd1,   8'h81},
    {1'b1, 8'd9,   8'h00},
    {1'b1, 8'd3,   8'hC6}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       lp_mode = 1'b0;
  logic [7:0] lp_div = 8'd0;
  logic       tx_nrz = 1'b1;
  logic       rx_drv = 1'b1;
  logic       loop_en = 1'b0;
  logic       rx_ir;
  logic       ir_tx;
  logic       rx_nrz;
  logic [2:0] tdiv = 3'd0;

  int tests = 0;
  int fails = 0;
  int exp_w = 24;
  int cur_w = 0;
  int pulses = 0;
  int width_bad = 0;
  int last_bad = 0;

  assign rx_ir = loop_en ? ~ir_tx : rx_drv;

  always #2.5 clk = ~clk;

  irda_sir_codec u_irda_sir_codec (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .lp_mode(lp_mode),
    .lp_div(lp_div), .tx_nrz(tx_nrz), .rx_ir(rx_ir), .ir_tx(ir_tx),
    .rx_nrz(rx_nrz)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv   <= 3'd0;
      tick16 <= 1'b0;
    end else begin
      tdiv   <= tdiv + 3'd1;
      tick16 <= (tdiv == 3'd7);
    end
  end

  always @(negedge clk) begin
    if (ir_tx) begin
      cur_w = cur_w + 1;
    end else if (cur_w != 0) begin
      pulses = pulses + 1;
      if (cur_w != exp_w) begin
        width_bad = width_bad + 1;
        last_bad  = cur_w;
      end
      cur_w = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Returns just after the posedge that consumed a tick.
  task automatic after_tick();
    @(negedge clk);
    while (!tick16) @(negedge clk);
  endtask

  // Drive a low of len cycles on rx_ir, watch rx_nrz, count ticks spent decoding.
  task automatic rx_pulse(input int len, output bit saw_low, output int act_ticks);
    bit prev;
    prev = 1'b1;
    saw_low = 1'b0;
    act_ticks = 0;
    for (int i = 0; i < len + 220; i++) begin
      @(negedge clk);
      if (tick16 && !prev) act_ticks = act_ticks + 1;
      prev = rx_nrz;
      if (!rx_nrz) saw_low = 1'b1;
      rx_drv = (i < len) ? 1'b0 : 1'b1;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit saw;
    int tk;
    int p0;
    int b0;
    int zeros;
    logic [16:0] e;

    repeat (3) @(negedge clk);
    check(ir_tx == 1'b0, "R1 reset ir_tx", int'(ir_tx), 0);
    check(rx_nrz == 1'b1, "R1 reset rx_nrz", int'(rx_nrz), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ir_tx == 1'b0 && rx_nrz == 1'b1, "R1 after reset", int'({ir_tx, rx_nrz}), 1);

    // R1: idle line of ones, no pulse
    p0 = pulses;
    for (int k = 0; k < 64; k++) after_tick();
    check(pulses == p0, "R1 idle no pulse", pulses - p0, 0);

    // Vector table: loopback byte transfer, R2 R3 R5 R10
    loop_en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      e = VEC[v];
      @(negedge clk);
      lp_mode = e[16];
      lp_div  = e[15:8];
      exp_w   = e[16] ? 3 * ((e[15:8] == 8'd0) ? 1 : int'(e[15:8])) : 3 * TICK_CYC;
      zeros = 0;
      for (int b = 0; b < 8; b++) if (!e[b]) zeros = zeros + 1;
      for (int k = 0; k < 4; k++) after_tick();
      p0 = pulses;
      b0 = width_bad;
      for (int b = 0; b < 8; b++) begin
        after_tick();
        tx_nrz = e[b];
        for (int k = 0; k < 9; k++) after_tick();
        check(rx_nrz == e[b], "R10 loopback bit", int'(rx_nrz), int'(e[b]));
        for (int k = 0; k < 6; k++) after_tick();
      end
      after_tick();
      tx_nrz = 1'b1;
      for (int k = 0; k < 40; k++) after_tick();
      check(pulses - p0 == zeros, "R1 one pulse per zero bit", pulses - p0, zeros);
      check(width_bad == b0, e[16] ? "R3 lp pulse width" : "R2 R5 normal pulse width",
            last_bad, exp_w);
      check(rx_nrz == 1'b1 && ir_tx == 1'b0, "R9 line idle after byte",
            int'({ir_tx, rx_nrz}), 1);
    end
    loop_en = 1'b0;

    // Low-power glitch filter, D = 5: threshold 11 cycles
    @(negedge clk);
    lp_mode = 1'b1;
    lp_div  = 8'd5;
    rx_pulse(3, saw, tk);
    check(!saw, "R7 lp low shorter than one period", int'(saw), 0);
    rx_pulse(10, saw, tk);
    check(!saw, "R7 lp low of two periods", int'(saw), 0);
    rx_pulse(11, saw, tk);
    check(saw, "R8 lp low just over two periods", int'(saw), 1);
    check(rx_nrz == 1'b1, "R9 lp window released", int'(rx_nrz), 1);

    // Zero prescaler acts as one: threshold 3 cycles
    @(negedge clk);
    lp_div = 8'd0;
    rx_pulse(2, saw, tk);
    check(!saw, "R4 div zero rejects 2 cycles", int'(saw), 0);
    rx_pulse(3, saw, tk);
    check(saw, "R4 div zero accepts 3 cycles", int'(saw), 1);

    // Normal mode, prescaler ignored, no filter
    @(negedge clk);
    lp_mode = 1'b0;
    lp_div  = 8'd200;
    rx_pulse(1, saw, tk);
    check(saw, "R5 R6 normal accepts one-cycle low", int'(saw), 1);
    rx_pulse(2, saw, tk);
    check(tk == 16, "R9 decode window in ticks", tk, 16);
    check(rx_nrz == 1'b1, "R9 normal window released", int'(rx_nrz), 1);

    summary();
    $finish;
  end

endmodule